// File: doc/BRIEF.md
# BCD Clock-Calendar Timekeeping Counter

This block holds the current time and date as seven packed-BCD fields: seconds, minutes, hours, day of week, date of month, month and two-digit year. A single-cycle enable pulse, arriving once per second from an external prescaler, advances the seconds field. Carries ripple through minutes, hours, the weekday, the date, the month and the year. The hours field can run in a 24-hour format or in a 12-hour format with a PM flag. Date rollover follows the length of each month, including the leap-year February.

A host loads any field through a simple write port that takes a 3-bit field selector and a data byte. All seven fields are always visible on output buses, for readback and for alarm comparators. The same per-second pulse also drives a square-wave output, which an enable input gates onto the pin through an output-enable signal.

Top module: `rtc_calendar_core`

## Requirements
- R1: Field selector codes are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year; a write with selector 7 changes no field. After reset the fields read sec 00, min 00, hour 00 (24-hour), weekday 01, date 01, month 01, year 00.
- R2: On each tick the seconds count 00–59 in BCD. Seconds 59 wrap to 00 and advance minutes. Minutes 59 wrap to 00 and advance hours.
- R3: With hours bit 6 = 0 (24-hour), hours run 00–23 with bit 5 as the 20s tens bit. 23:59:59 wraps to 00:00:00 and advances the day.
- R4: With hours bit 6 = 1 (12-hour), bits 4:0 hold 01–12 and bit 5 is PM (1 = PM). 11 goes to 12 and inverts PM; 12 goes to 01 and keeps PM. The day advances only at 11:59:59 PM → 12:00:00 AM.
- R5: Each day advance moves the weekday 01→…→07→01.
- R6: The date wraps to 01 and advances the month after day 30 in months 04, 06, 09 and 11, and after day 31 in the other non-February months.
- R7: February ends at 29 when the year value is divisible by 4, otherwise at 28.
- R8: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R9: A write loads the selected field at the next clock edge, with unused bits forced to 0. The kept-bit masks are sec 7F, min 7F, hour 7F, weekday 07, date 3F, month 1F, year FF.
- R10: A write strobe (any selector) in the same cycle as a tick wins: the written field loads and no field advances in that cycle.
- R11: After each tick the square wave is high for HALF_PERIOD_CLKS clock cycles, then low. Its output-enable equals the enable input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field selector |
| wr_data | input | 8 | BCD write data |
| sqw_en | input | 1 | Square-wave output enable |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours with format and PM/20s bits |
| dow_o | output | 8 | Weekday 01–07 |
| date_o | output | 8 | Date of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year 00–99, BCD |
| sqw_o | output | 1 | Square-wave level |
| sqw_oe | output | 1 | Square-wave output enable |

## Verification
The embedded assertions check local step rules on every cycle:
- seconds wrap after 59;
- PM inverts on the 11→12 step;
- the weekday and end-of-month wraps;
- a write leaves unselected fields untouched;
- the square wave rises after a tick and falls after its half period.

Whole-calendar behaviour needs the bench's reference model driven through scenarios. This covers year-end cascades, leap and non-leap February, 30-day months, the full 12-hour sequence and masking of written unused bits.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DOW   = 3'd3,
    FLD_DATE  = 3'd4,
    FLD_MONTH = 3'd5,
    FLD_YEAR  = 3'd6,
    FLD_NONE  = 3'd7
  } fld_e;

  localparam logic [7:0] SEC_MASK   = 8'h7F;
  localparam logic [7:0] MIN_MASK   = 8'h7F;
  localparam logic [7:0] HOUR_MASK  = 8'h7F;
  localparam logic [7:0] DOW_MASK   = 8'h07;
  localparam logic [7:0] DATE_MASK  = 8'h3F;
  localparam logic [7:0] MONTH_MASK = 8'h1F;
  localparam logic [7:0] YEAR_MASK  = 8'hFF;

  // Two-digit BCD increment; 99 wraps to 00.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [3:0] lo;
    logic [3:0] hi;
    if (v[3:0] >= 4'd9) begin
      lo = 4'd0;
      hi = (v[7:4] >= 4'd9) ? 4'd0 : v[7:4] + 4'd1;
    end else begin
      lo = v[3:0] + 4'd1;
      hi = v[7:4];
    end
    return {hi, lo};
  endfunction

  // BCD year divisible by 4: even tens need units 0/4/8, odd tens need 2/6.
  function automatic logic bcd_leap(input logic [7:0] y);
    if (y[4] == 1'b0)
      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    else
      return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mo, input logic [7:0] y);
    case (mo)
      8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  fld_e       wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic       day_carry
);

  logic       step, min_inc, hour_inc, hour_end;
  logic       sec_en, min_en, hour_en;
  logic [7:0] sec_nxt, min_nxt, hour_nxt, hour_adv;
  logic [7:0] inc_h;
  logic       is12, pm;

  assign step     = tick & ~wr_en;
  assign min_inc  = step & (sec_q == 8'h59);
  assign hour_inc = min_inc & (min_q == 8'h59);
  assign is12     = hour_q[6];
  assign pm       = hour_q[5];
  assign hour_end = is12 ? (hour_q[5:0] == 6'h31) : (hour_q[5:0] == 6'h23);
  assign day_carry = hour_inc & hour_end;

  always_comb begin
    inc_h = 8'h00;
    if (is12) begin
      inc_h = bcd_inc({3'b000, hour_q[4:0]});
      if (hour_q[4:0] == 5'h12)      hour_adv = {2'b01, pm, 5'h01};
      else if (hour_q[4:0] == 5'h11) hour_adv = {2'b01, ~pm, 5'h12};
      else                           hour_adv = {2'b01, pm, inc_h[4:0]};
    end else begin
      inc_h = bcd_inc({2'b00, hour_q[5:0]});
      if (hour_q[5:0] == 6'h23)      hour_adv = 8'h00;
      else                           hour_adv = {2'b00, inc_h[5:0]};
    end
  end

  always_comb begin
    sec_en   = wr_en ? (wr_sel == FLD_SEC)  : step;
    min_en   = wr_en ? (wr_sel == FLD_MIN)  : min_inc;
    hour_en  = wr_en ? (wr_sel == FLD_HOUR) : hour_inc;
    sec_nxt  = wr_en ? (wr_data & SEC_MASK)  : ((sec_q == 8'h59) ? 8'h00 : bcd_inc(sec_q));
    min_nxt  = wr_en ? (wr_data & MIN_MASK)  : ((min_q == 8'h59) ? 8'h00 : bcd_inc(min_q));
    hour_nxt = wr_en ? (wr_data & HOUR_MASK) : hour_adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else begin
      if (sec_en)  sec_q  <= sec_nxt;
      if (min_en)  min_q  <= min_nxt;
      if (hour_en) hour_q <= hour_nxt;
    end
  end

  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && sec_q == 8'h59) |=> (sec_q == 8'h00));

  a_r4_pm_flips_at_eleven: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_inc && hour_q[6] && hour_q[4:0] == 5'h11) |=> (hour_q[5] != $past(hour_q[5])));

  a_r10_write_holds_sec: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel != FLD_SEC) |=> $stable(sec_q));

  a_r9_min_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == FLD_MIN) |=> (min_q == ($past(wr_data) & MIN_MASK)));

endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_carry,
  input  logic       wr_en,
  input  fld_e       wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] dow_q,
  output logic [7:0] date_q,
  output logic [7:0] month_q,
  output logic [7:0] year_q
);

  logic       date_end, month_inc, year_inc;
  logic       dow_en, date_en, month_en, year_en;
  logic [7:0] dow_nxt, date_nxt, month_nxt, year_nxt;

  assign date_end  = (date_q == month_last(month_q, year_q));
  assign month_inc = day_carry & date_end;
  assign year_inc  = month_inc & (month_q == 8'h12);

  always_comb begin
    dow_en    = wr_en ? (wr_sel == FLD_DOW)   : day_carry;
    date_en   = wr_en ? (wr_sel == FLD_DATE)  : day_carry;
    month_en  = wr_en ? (wr_sel == FLD_MONTH) : month_inc;
    year_en   = wr_en ? (wr_sel == FLD_YEAR)  : year_inc;
    dow_nxt   = wr_en ? (wr_data & DOW_MASK)   : ((dow_q == 8'h07) ? 8'h01 : dow_q + 8'h01);
    date_nxt  = wr_en ? (wr_data & DATE_MASK)  : (date_end ? 8'h01 : bcd_inc(date_q));
    month_nxt = wr_en ? (wr_data & MONTH_MASK) : ((month_q == 8'h12) ? 8'h01 : bcd_inc(month_q));
    year_nxt  = wr_en ? (wr_data & YEAR_MASK)  : bcd_inc(year_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dow_q   <= 8'h01;
      date_q  <= 8'h01;
      month_q <= 8'h01;
      year_q  <= 8'h00;
    end else begin
      if (dow_en)   dow_q   <= dow_nxt;
      if (date_en)  date_q  <= date_nxt;
      if (month_en) month_q <= month_nxt;
      if (year_en)  year_q  <= year_nxt;
    end
  end

  a_r5_dow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && !wr_en && dow_q == 8'h07) |=> (dow_q == 8'h01));

  a_r6_month_end_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && !wr_en && date_end) |=> (date_q == 8'h01));

  a_r10_write_holds_year: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel != FLD_YEAR) |=> $stable(year_q));

endmodule

// File: rtl/rtc_sqw_gen.sv
module rtc_sqw_gen #(
  parameter int HALF_PERIOD_CLKS = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  output logic sqw,
  output logic sqw_oe
);

  localparam int CW = $clog2(HALF_PERIOD_CLKS + 1);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          lvl_q, lvl_nxt;
  logic          upd;

  always_comb begin
    upd     = tick | lvl_q;
    cnt_nxt = tick ? CW'(HALF_PERIOD_CLKS) : cnt_q - CW'(1);
    lvl_nxt = tick ? 1'b1 : (cnt_q != CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (upd) begin
      cnt_q <= cnt_nxt;
      lvl_q <= lvl_nxt;
    end
  end

  assign sqw    = lvl_q;
  assign sqw_oe = en;

  a_r11_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> lvl_q);

  a_r11_fall_after_half: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && lvl_q && cnt_q == CW'(1)) |=> !lvl_q);

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
#(
  parameter int HALF_PERIOD_CLKS = 16384
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       sqw_en,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic       sqw_o,
  output logic       sqw_oe
);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       day_carry;
  fld_e       wr_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign wr_sel = fld_e'(wr_addr);

  rtc_time_chain u_time (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (tick_1hz),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .sec_q     (sec_o),
    .min_q     (min_o),
    .hour_q    (hour_o),
    .day_carry (day_carry)
  );

  rtc_date_chain u_date (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .day_carry (day_carry),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .dow_q     (dow_o),
    .date_q    (date_o),
    .month_q   (month_o),
    .year_q    (year_o)
  );

  rtc_sqw_gen #(.HALF_PERIOD_CLKS(HALF_PERIOD_CLKS)) u_sqw (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick   (tick_1hz),
    .en     (sqw_en),
    .sqw    (sqw_o),
    .sqw_oe (sqw_oe)
  );

  a_r1_unused_sel_no_change: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && wr_addr == 3'd7) |=> ($stable(sec_o) && $stable(hour_o) && $stable(date_o)));

endmodule

// File: tb/tb_rtc_calendar_core.sv
`timescale 1ns/1ps
module tb_rtc_calendar_core;

  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_1hz, wr_en, sqw_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
  logic       sqw_o, sqw_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model in plain integers
  int s, m, h, dw, d, mo, y;
  bit mode12;

  always #2 clk = ~clk;

  rtc_calendar_core #(.HALF_PERIOD_CLKS(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sqw_en(sqw_en),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o),
    .sqw_o(sqw_o), .sqw_oe(sqw_oe)
  );

  function automatic logic [7:0] to_bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic int mdays(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hour_exp();
    int h12;
    if (mode12) begin
      h12 = (h % 12 == 0) ? 12 : h % 12;
      return 8'h40 | ((h >= 12) ? 8'h20 : 8'h00) | to_bcd(h12);
    end
    return to_bcd(h);
  endfunction

  task automatic model_tick();
    s++;
    if (s == 60) begin
      s = 0; m++;
      if (m == 60) begin
        m = 0; h++;
        if (h == 24) begin
          h = 0;
          dw = (dw == 7) ? 1 : dw + 1;
          d++;
          if (d > mdays(mo, y)) begin
            d = 1; mo++;
            if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic cmp(input string tag, input string f, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, f, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cmp(tag, "sec",   sec_o,   to_bcd(s));
    cmp(tag, "min",   min_o,   to_bcd(m));
    cmp(tag, "hour",  hour_o,  hour_exp());
    cmp(tag, "dow",   dow_o,   to_bcd(dw));
    cmp(tag, "date",  date_o,  to_bcd(d));
    cmp(tag, "month", month_o, to_bcd(mo));
    cmp(tag, "year",  year_o,  to_bcd(y));
  endtask

  // one clock: drive after a negedge, result visible at the next negedge
  task automatic cyc(input logic t, input logic w, input logic [2:0] a, input logic [7:0] dt);
    tick_1hz = t; wr_en = w; wr_addr = a; wr_data = dt;
    @(negedge clk);
    tick_1hz = 1'b0; wr_en = 1'b0;
  endtask

  task automatic set_all(input bit md, input int hh, input int mi, input int ss,
                         input int dww, input int dd, input int mm, input int yy);
    logic [7:0] hb;
    mode12 = md; h = hh; m = mi; s = ss; dw = dww; d = dd; mo = mm; y = yy;
    hb = hour_exp();
    cyc(0, 1, 3'd6, to_bcd(yy));
    cyc(0, 1, 3'd5, to_bcd(mm));
    cyc(0, 1, 3'd4, to_bcd(dd));
    cyc(0, 1, 3'd3, to_bcd(dww));
    cyc(0, 1, 3'd2, hb);
    cyc(0, 1, 3'd1, to_bcd(mi));
    cyc(0, 1, 3'd0, to_bcd(ss));
  endtask

  task automatic tick_chk(input string tag);
    cyc(1, 0, 3'd0, 8'h00);
    model_tick();
    check_all(tag);
  endtask

  task automatic rand_write(output logic [2:0] a, output logic [7:0] dt);
    int f;
    int h12;
    bit pm;
    f = $urandom_range(0, 6);
    if ((f == 5 || f == 6) && d > 28) f = 0;
    case (f)
      0: begin s = $urandom_range(0, 59); dt = to_bcd(s); end
      1: begin m = $urandom_range(0, 59); dt = to_bcd(m); end
      2: begin
           mode12 = 1'($urandom_range(0, 1));
           if (mode12) begin
             h12 = $urandom_range(1, 12); pm = 1'($urandom_range(0, 1));
             h = (h12 == 12) ? (pm ? 12 : 0) : (pm ? h12 + 12 : h12);
           end else h = $urandom_range(0, 23);
           dt = hour_exp();
         end
      3: begin dw = $urandom_range(1, 7); dt = to_bcd(dw); end
      4: begin d = $urandom_range(1, 28); dt = to_bcd(d); end
      5: begin mo = $urandom_range(1, 12); dt = to_bcd(mo); end
      default: begin y = $urandom_range(0, 99); dt = to_bcd(y); end
    endcase
    a = 3'(f);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [2:0] a;
    logic [7:0] dt;
    void'($urandom(32'd1234));
    rst_n = 1'b0; tick_1hz = 1'b0; wr_en = 1'b0; wr_addr = 3'd0; wr_data = 8'h00; sqw_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    s = 0; m = 0; h = 0; mode12 = 0; dw = 1; d = 1; mo = 1; y = 0;
    check_all("R1 reset");
    cmp("R11 reset", "sqw", {7'b0, sqw_o}, 8'h00);
    cmp("R11 reset", "oe", {7'b0, sqw_oe}, 8'h00);

    // R9 unused bits forced to zero
    cyc(0, 1, 3'd0, 8'hD9); s = 59;
    cyc(0, 1, 3'd2, 8'h92); h = 12;
    cyc(0, 1, 3'd3, 8'hF5); dw = 5;
    cyc(0, 1, 3'd4, 8'hD7); d = 17;
    cyc(0, 1, 3'd5, 8'hE9); mo = 9;
    check_all("R9 masked write");

    // R2 minute carry
    set_all(0, 5, 0, 59, 2, 10, 6, 30);
    tick_chk("R2 sec wrap");
    set_all(0, 5, 59, 59, 2, 10, 6, 30);
    tick_chk("R2 min wrap");

    // R3 R5 R8 year end in 24-hour mode
    set_all(0, 23, 59, 59, 7, 31, 12, 99);
    tick_chk("R3 R5 R8 year end");

    // R7 leap and non-leap February
    set_all(0, 23, 59, 59, 3, 28, 2, 24);
    tick_chk("R7 leap 28->29");
    set_all(0, 23, 59, 59, 4, 29, 2, 24);
    tick_chk("R7 leap 29->1");
    set_all(0, 23, 59, 59, 4, 28, 2, 23);
    tick_chk("R7 non-leap 28->1");

    // R6 30-day and 31-day months
    set_all(0, 23, 59, 59, 1, 30, 4, 21);
    tick_chk("R6 april end");
    set_all(0, 23, 59, 59, 1, 30, 5, 21);
    tick_chk("R6 may 30->31");

    // R4 12-hour sequence
    set_all(1, 11, 59, 59, 6, 15, 8, 40);
    tick_chk("R4 11AM->12PM");
    set_all(1, 12, 59, 59, 6, 15, 8, 40);
    tick_chk("R4 12PM->01PM");
    set_all(1, 0, 59, 59, 6, 15, 8, 40);
    tick_chk("R4 12AM->01AM");
    set_all(1, 23, 59, 59, 6, 15, 8, 40);
    tick_chk("R4 11PM->12AM day");

    // R10 write with tick: write wins, nothing advances
    set_all(0, 23, 59, 59, 7, 31, 12, 99);
    cyc(1, 1, 3'd1, 8'h30); m = 30;
    check_all("R10 write over tick");

    // R1 selector 7 ignored, and it still blocks the tick (R10)
    cyc(0, 1, 3'd7, 8'h11);
    check_all("R1 selector 7");
    cyc(1, 1, 3'd7, 8'h11);
    check_all("R10 selector 7 with tick");

    // R11 square wave
    sqw_en = 1'b1;
    @(negedge clk);
    cmp("R11 enable", "oe", {7'b0, sqw_oe}, 8'h01);
    cyc(1, 0, 3'd0, 8'h00); model_tick();
    cmp("R11 after tick", "sqw", {7'b0, sqw_o}, 8'h01);
    repeat (HALF - 1) @(negedge clk);
    cmp("R11 last high", "sqw", {7'b0, sqw_o}, 8'h01);
    @(negedge clk);
    cmp("R11 low", "sqw", {7'b0, sqw_o}, 8'h00);
    sqw_en = 1'b0;
    @(negedge clk);
    cmp("R11 disable", "oe", {7'b0, sqw_oe}, 8'h00);
    check_all("R11 time kept");

    // random mix: R2 ticks, R9 writes, R10 collisions
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 6) begin
        cyc(1, 0, 3'd0, 8'h00); model_tick();
        check_all("R2 random tick");
      end else begin
        rand_write(a, dt);
        cyc((r == 9) ? 1'b1 : 1'b0, 1'b1, a, dt);
        check_all((r == 9) ? "R10 random collide" : "R9 random write");
      end
    end

    finish_run();
  end

endmodule